// File: doc/BRIEF.md
# Path-Compressed Trie Prefix Lookup Engine

This block finds the longest stored IPv4 prefix that covers a 32-bit destination address and returns that route's next hop. The routes sit in a binary trie in an on-chip node memory. Chains of one-way branches are collapsed, so each node records which address bit it tests. The engine starts at the root and follows the left child when the tested bit is 0 and the right child when it is 1. The walk stops when it reaches a null child.

A node may also carry a route, given as a prefix value, a length and a next hop. Because the walk skips the collapsed bits, the engine compares each route it meets against the full address under that route's mask. A best-match register keeps the most recent route that passed this compare, and that register is the result. If the last candidate fails the compare, the answer therefore falls back to an earlier, shorter route such as a 0/0 default. If no route matched at all, the result is a miss.

Requests enter on a valid/ready handshake, and one lookup runs at a time. `req_ready` is high only while the engine is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The result is offered with `res_valid` and held unchanged until `res_ready` is seen high on a clock edge. Software loads nodes through a plain write port.

Top module: `lpm_trie_walk`

## Requirements
- R1: When several stored routes cover the address, the result is the next hop of the longest one, so a /24 route wins over a covering /16.
- R2: A node tests address bit `addr[test_pos]`, where 31 is the most significant bit. A 0 moves the walk to the left child and a 1 moves it to the right child.
- R3: A route on a visited node is taken only if its prefix equals the address in all of its top `len` bits. If the last candidate fails this compare, the result is the best earlier route that passed it.
- R4: A route of length 0 (0/0) matches every address and is returned when no longer route matches.
- R5: When no route matches, the result has `res_hit`=0 and `res_nh`=0.
- R6: `req_ready` is low from the edge that accepts a request until the edge that accepts its result. While `res_valid` is high and `res_ready` is low, `res_valid`, `res_hit` and `res_nh` hold their values.
- R7: The root is node 0. A child pointer of 0 is null and ends the walk.
- R8: The node word, from MSB to LSB, holds: test position [63:59], left child [58:53], right child [52:47], route-present flag [46], prefix value [45:14], prefix length 0..32 [13:8], next hop [7:0]. A node write on the same edge as a read of that node gives the walk the old contents, and later lookups see the new contents.
- R9: During and right after reset, `req_ready`=1 and `res_valid`=0.
- R10: A walk visits at most MAX_STEPS (default 33) nodes and then returns its best match so far, even if the node table contains a loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine idle; request can be taken |
| req_addr | input | 32 | Destination address to look up |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | A route matched |
| res_nh | output | 8 | Next hop of the matched route, 0 on a miss |
| wr_en | input | 1 | Node write strobe |
| wr_idx | input | 6 | Node index to write |
| wr_node | input | 64 | Node word, with the layout given in R8 |

## Verification
A software node write and a lookup's read of that same node can fall on the same clock edge. The most exposed case is the root, because the root is read on the very edge that accepts a request. The bench provokes this by presenting a request and a write to the root in the same cycle. The new root word restores a default route that the old word lacked. The lookup must still report a miss, and the lookup that follows must return the default next hop.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ADDR_W = 32;
  localparam int POS_W  = $clog2(ADDR_W);
  localparam int IDX_W  = 6;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int LEN_W  = $clog2(ADDR_W + 1);
  localparam int NH_W   = 8;

  typedef struct packed {
    logic [POS_W-1:0]  test_pos;
    logic [IDX_W-1:0]  left;
    logic [IDX_W-1:0]  right;
    logic              pfx_ok;
    logic [ADDR_W-1:0] pfx_val;
    logic [LEN_W-1:0]  pfx_len;
    logic [NH_W-1:0]   nh;
  } node_t;

  localparam int NODE_W = $bits(node_t);
endpackage

// File: rtl/lpm_node_ram.sv
module lpm_node_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // read-before-write on a shared address: rdata carries the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lpm_prefix_cmp.sv
module lpm_prefix_cmp #(
  parameter int AW = 32,
  localparam int LW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] pfx,
  input  logic [LW-1:0] len,
  output logic          match
);
  logic [AW-1:0] mask;

  // bit i is inside the mask when it lies within the top len bits
  for (genvar i = 0; i < AW; i++) begin : g_mask
    assign mask[i] = (LW'(AW - 1 - i) < len);
  end

  assign match = ((addr ^ pfx) & mask) == '0;
endmodule

// File: rtl/lpm_trie_walk.sv
module lpm_trie_walk
  import lpm_pkg::*;
#(
  parameter int MAX_STEPS = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [NH_W-1:0]   res_nh,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [NODE_W-1:0] wr_node
);
  localparam int STEP_W = $clog2(MAX_STEPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_DONE} state_t;

  state_t            state;
  logic [ADDR_W-1:0] addr_q;
  logic              best_hit;
  logic [NH_W-1:0]   best_nh;
  logic [STEP_W-1:0] steps;

  node_t             node;
  logic [NODE_W-1:0] node_raw;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  child;
  logic              pfx_match;
  logic              take;
  logic              last_step;

  lpm_node_ram #(.DEPTH(DEPTH), .W(NODE_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (wr_node),
    .raddr (rd_idx),
    .rdata (node_raw)
  );

  assign node = node_t'(node_raw);

  lpm_prefix_cmp #(.AW(ADDR_W)) u_cmp (
    .addr  (addr_q),
    .pfx   (node.pfx_val),
    .len   (node.pfx_len),
    .match (pfx_match)
  );

  always_comb begin
    take      = node.pfx_ok && pfx_match;
    child     = addr_q[node.test_pos] ? node.right : node.left;
    last_step = (child == '0) || (steps == STEP_W'(MAX_STEPS - 1));
    // idle: keep the root on the read port so it is ready at acceptance
    rd_idx    = (state == S_IDLE) ? '0 : child;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      best_hit <= 1'b0;
      best_nh  <= '0;
      steps    <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          addr_q   <= req_addr;
          best_hit <= 1'b0;
          best_nh  <= '0;
          steps    <= '0;
          state    <= S_WALK;
        end
        S_WALK: begin
          if (take) begin
            best_hit <= 1'b1;
            best_nh  <= node.nh;
          end
          steps <= steps + 1'b1;
          if (last_step) state <= S_DONE;
        end
        S_DONE: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign res_valid = (state == S_DONE);
  assign res_hit   = best_hit;
  assign res_nh    = best_nh;
endmodule

// File: rtl/lpm_trie_walk_chk.sv
module lpm_trie_walk_chk #(
  parameter int MAX_STEPS = 33
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       res_valid,
  input logic       res_ready,
  input logic       res_hit,
  input logic [7:0] res_nh
);
  int busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else if (!req_ready && !res_valid) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= 0;
  end

  // R6
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_nh));

  // R6
  busy_while_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  // R5
  miss_zero_nh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_nh == 8'd0);

  // R10
  walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= MAX_STEPS);
endmodule

bind lpm_trie_walk lpm_trie_walk_chk #(.MAX_STEPS(MAX_STEPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_hit   (res_hit),
  .res_nh    (res_nh)
);

// File: tb/tb_lpm_trie_walk.sv
module tb_lpm_trie_walk;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_STEPS  = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_hit;
  logic [7:0]  res_nh;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_node = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lpm_trie_walk #(.MAX_STEPS(MAX_STEPS)) dut (.*);

  function automatic logic [63:0] mk(input logic [4:0] pos, input logic [5:0] l,
      input logic [5:0] r, input logic ok, input logic [31:0] v,
      input logic [5:0] len, input logic [7:0] nh);
    return {pos, l, r, ok, v, len, nh};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [63:0] n);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_node = n;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // issues a lookup, waits for the result, returns {hit,nh} and walk cycles
  task automatic look(input logic [31:0] a, output logic [8:0] r, output int cycles);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!res_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    cycles = n;
    r = {res_hit, res_nh};
    if (!res_valid) begin
      fails++;
      checks++;
      $display("FAIL R6: actual no result expected result");
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  localparam int NV = 7;
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h80029907, 32'h80020101, 32'h8002C805, 32'h0A010203,
    32'h0B000001, 32'h81000001, 32'hC0A80001};
  localparam logic [8:0] V_EXP [NV] = '{
    {1'b1, 8'd3}, {1'b1, 8'd2}, {1'b1, 8'd2}, {1'b1, 8'd4},
    {1'b1, 8'd1}, {1'b1, 8'd1}, {1'b1, 8'd1}};
  localparam string V_REQ [NV] = '{
    "R1 /24 over /16", "R2 R7 bit 0 to null left", "R3 final compare fails",
    "R2 left branch /8", "R3 R4 fallback to default", "R4 default after miss",
    "R4 default"};

  initial begin
    logic [8:0] r;
    int cy;
    // R9 reset state
    repeat (2) @(negedge clk);
    chk("R9 ready in reset", 32'(req_ready), 32'd1);
    chk("R9 no result in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ready after reset", 32'(req_ready), 32'd1);
    chk("R9 no result after reset", 32'(res_valid), 32'd0);

    wr(6'd0, mk(5'd31, 6'd1, 6'd2, 1'b1, 32'h0, 6'd0, 8'd1));
    wr(6'd1, mk(5'd0, 6'd0, 6'd0, 1'b1, 32'h0A000000, 6'd8, 8'd4));
    wr(6'd2, mk(5'd15, 6'd0, 6'd3, 1'b1, 32'h80020000, 6'd16, 8'd2));
    wr(6'd3, mk(5'd0, 6'd0, 6'd0, 1'b1, 32'h80029900, 6'd24, 8'd3));

    for (int i = 0; i < NV; i++) begin
      look(V_ADDR[i], r, cy);
      chk(V_REQ[i], 32'(r), 32'(V_EXP[i]));
    end

    // R6 result held under back-pressure, request blocked
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h80029907;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 ready low while walking", 32'(req_ready), 32'd0);
    repeat (8) @(negedge clk);
    chk("R6 result valid held", 32'(res_valid), 32'd1);
    chk("R6 ready low with result", 32'(req_ready), 32'd0);
    chk("R6 result held value", 32'({res_hit, res_nh}), 32'({1'b1, 8'd3}));
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R6 ready after take", 32'(req_ready), 32'd1);

    // R5 miss without default route
    wr(6'd0, mk(5'd31, 6'd1, 6'd2, 1'b0, 32'h0, 6'd0, 8'd1));
    look(32'h0B000001, r, cy);
    chk("R5 miss", 32'(r), 32'd0);

    // R8 root write on the same edge as the root read
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0B000001;
    wr_en = 1'b1; wr_idx = 6'd0;
    wr_node = mk(5'd31, 6'd1, 6'd2, 1'b1, 32'h0, 6'd0, 8'd1);
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    while (!res_valid && cyc < 100000) @(negedge clk);
    chk("R8 old root seen", 32'({res_hit, res_nh}), 32'd0);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    look(32'h0B000001, r, cy);
    chk("R8 new root seen", 32'(r), 32'({1'b1, 8'd1}));

    // R10 looping table ends after MAX_STEPS visits
    wr(6'd1, mk(5'd0, 6'd1, 6'd1, 1'b0, 32'h0, 6'd0, 8'd9));
    look(32'h0B000001, r, cy);
    chk("R10 loop result", 32'(r), 32'({1'b1, 8'd1}));
    chk("R10 loop bounded", 32'(cy <= MAX_STEPS), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule